// File: doc/BRIEF.md
# Ordered Dial Combination Lock Controller

This block is a clocked finite state machine that releases a lock only after three dial operations arrive in one fixed order. Each operation is a turn direction plus a 5-bit dial number. Both arrive already decoded, together with a one-cycle valid strobe. The machine moves one step forward for every operation that matches the next expected step. Any other strobed operation sends it back to the start. After the third matching operation it raises its unlocked output and holds it.

Two inputs return the machine to the start. A relock input takes the open lock back to the start, and a synchronous reset clears it from any state. The three steps are parameters, and the default combination is right to 13, then left to 22, then right to 3. Dial sensing, debouncing and actuator control sit outside this block.

Top module: `seq_lock_fsm`

## Requirements
- R1: A synchronous active-high reset puts the machine in its start state on the next rising edge, with unlocked low. Reset works from any state, including open.
- R2: The state is kept in a 2-bit edge-triggered register with four values: start, one step done, two steps done and open. Each state change either moves one step forward or returns to start. unlocked is 1 only in the open state.
- R3: An operation is examined only on a rising edge where op_valid is 1. With op_valid low and relock low, the state does not change, whatever op_dir and op_num hold.
- R4: The operations right 13, left 22, right 3, given in that order, open the lock. unlocked goes high in the cycle after the edge that accepts the third operation, and it stays low before that.
- R5: A step matches only when both op_dir and op_num equal the expected values. op_dir encodes right as 1 and left as 0, so a correct number turned the wrong way is a mismatch.
- R6: A strobed operation that does not match the expected next step returns the machine to start, not to the step before. The operation is not re-examined as a first step.
- R7: The three correct operations given in any order other than the required one leave the lock closed.
- R8: While the lock is open, relock high at a rising edge returns the machine to start. In the other states relock has no effect on the progress already made.
- R9: While the lock is open, strobed operations are ignored and the lock stays open.
- R10: The direction and number of each of the three steps are parameters, with defaults right 13, left 22 and right 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Strobe: the dial operation on op_dir/op_num is present this cycle |
| op_dir | input | 1 | Turn direction, 1 = right, 0 = left |
| op_num | input | 5 | Dial number reached by the turn |
| relock | input | 1 | Closes an open lock |
| unlocked | output | 1 | High while the lock is open |

## Verification
The bench targets the two ways a lock can open too easily. A design that compares only the dial number would open after a correct number turned the wrong way. A design that falls back one step on a miss, instead of to start, would open after a stray operation in the middle of the sequence. The bench also gives the right values in the wrong order, and it holds op_valid low while the data lines show the correct next step; a design that did not require the strobe would advance in that case. Finally, it sends operations while the lock is open, which would close a design that does not ignore them, and it asserts relock before the lock opens, which would wipe progress in a design that applies relock in every state.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;

    localparam int DIAL_W    = 5;
    localparam int NUM_STEPS = 3;
    localparam int STATE_W   = 2;

    typedef enum logic [STATE_W-1:0] {
        LK_START = 2'd0,
        LK_ONE   = 2'd1,
        LK_TWO   = 2'd2,
        LK_OPEN  = 2'd3
    } lock_state_e;

    typedef struct packed {
        logic              dir;   // 1 = right, 0 = left
        logic [DIAL_W-1:0] num;
    } dial_op_t;

    function automatic lock_state_e step_forward(input lock_state_e s);
        lock_state_e r;
        case (s)
            LK_START: r = LK_ONE;
            LK_ONE:   r = LK_TWO;
            default:  r = LK_OPEN;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/seq_lock_step_match.sv
module seq_lock_step_match
    import seq_lock_pkg::*;
#(
    parameter logic [NUM_STEPS-1:0]        STEP_DIRS = 3'b101,
    parameter logic [NUM_STEPS*DIAL_W-1:0] STEP_NUMS = {5'd3, 5'd22, 5'd13}
) (
    input  dial_op_t             op,
    output logic [NUM_STEPS-1:0] hit
);
    for (genvar i = 0; i < NUM_STEPS; i++) begin : g_step
        assign hit[i] = (op.dir == STEP_DIRS[i]) &&
                        (op.num == STEP_NUMS[i*DIAL_W +: DIAL_W]);
    end
endmodule

// File: rtl/seq_lock_next.sv
module seq_lock_next
    import seq_lock_pkg::*;
(
    input  lock_state_e          cur,
    input  logic                 op_valid,
    input  logic                 relock,
    input  logic [NUM_STEPS-1:0] hit,
    output lock_state_e          nxt
);
    logic expected_hit;

    always_comb begin
        case (cur)
            LK_START: expected_hit = hit[0];
            LK_ONE:   expected_hit = hit[1];
            LK_TWO:   expected_hit = hit[2];
            default:  expected_hit = 1'b0;
        endcase
    end

    always_comb begin
        nxt = cur;
        if (cur == LK_OPEN) begin
            if (relock) nxt = LK_START;
        end else if (op_valid) begin
            nxt = expected_hit ? step_forward(cur) : LK_START;
        end
    end
endmodule

// File: rtl/seq_lock_state_reg.sv
module seq_lock_state_reg
    import seq_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  lock_state_e nxt,
    output lock_state_e cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= LK_START;
        else     cur <= nxt;
    end
endmodule

// File: rtl/seq_lock_fsm.sv
module seq_lock_fsm
    import seq_lock_pkg::*;
#(
    parameter logic [NUM_STEPS-1:0]        STEP_DIRS = 3'b101,
    parameter logic [NUM_STEPS*DIAL_W-1:0] STEP_NUMS = {5'd3, 5'd22, 5'd13}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              op_dir,
    input  logic [DIAL_W-1:0] op_num,
    input  logic              relock,
    output logic              unlocked
);
    dial_op_t             op_in;
    logic [NUM_STEPS-1:0] step_hit;
    lock_state_e          state_q;
    lock_state_e          state_d;

    assign op_in.dir = op_dir;
    assign op_in.num = op_num;

    seq_lock_step_match #(
        .STEP_DIRS(STEP_DIRS),
        .STEP_NUMS(STEP_NUMS)
    ) u_match (
        .op  (op_in),
        .hit (step_hit)
    );

    seq_lock_next u_next (
        .cur      (state_q),
        .op_valid (op_valid),
        .relock   (relock),
        .hit      (step_hit),
        .nxt      (state_d)
    );

    seq_lock_state_reg u_sreg (
        .clk (clk),
        .rst (rst),
        .nxt (state_d),
        .cur (state_q)
    );

    assign unlocked = (state_q == LK_OPEN);
endmodule

// File: rtl/seq_lock_fsm_chk.sv
module seq_lock_fsm_chk
    import seq_lock_pkg::*;
#(
    parameter logic [NUM_STEPS-1:0]        STEP_DIRS = 3'b101,
    parameter logic [NUM_STEPS*DIAL_W-1:0] STEP_NUMS = {5'd3, 5'd22, 5'd13}
) (
    input logic               clk,
    input logic               rst,
    input logic               op_valid,
    input logic               op_dir,
    input logic [DIAL_W-1:0]  op_num,
    input logic               relock,
    input logic               unlocked,
    input logic [STATE_W-1:0] state
);
    logic rst_seen = 1'b0;
    logic exp_match;

    always_ff @(posedge clk) rst_seen <= rst;

    always @(posedge clk) begin
        if (rst_seen) begin
            a_r1_reset_start: assert (state == 2'd0 && !unlocked)
                else $error("R1 state not cleared by reset");
        end
    end

    always_comb begin
        exp_match = 1'b0;
        if (state != 2'd3)
            exp_match = (op_dir == STEP_DIRS[state]) &&
                        (op_num == STEP_NUMS[state*DIAL_W +: DIAL_W]);
    end

    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        (state != $past(state) && state != 2'd0) |-> state == $past(state) + 2'd1);

    a_r3_hold_no_strobe: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !relock) |=> $stable(state));

    a_r4_open_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> ($past(op_valid) && $past(state) == 2'd2 &&
                             $past(op_dir) == STEP_DIRS[2] &&
                             $past(op_num) == STEP_NUMS[2*DIAL_W +: DIAL_W]));

    a_r6_miss_to_start: assert property (@(posedge clk) disable iff (rst)
        (op_valid && state != 2'd3 && !exp_match) |=> state == 2'd0);

    a_r8_relock_closes: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd3 && relock) |=> (state == 2'd0 && !unlocked));

    a_r9_open_ignores_ops: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd3 && !relock) |=> unlocked);
endmodule

bind seq_lock_fsm seq_lock_fsm_chk #(
    .STEP_DIRS(STEP_DIRS),
    .STEP_NUMS(STEP_NUMS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_dir   (op_dir),
    .op_num   (op_num),
    .relock   (relock),
    .unlocked (unlocked),
    .state    (state_q)
);

// File: tb/seq_lock_fsm_bench.sv
module seq_lock_fsm_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic R = 1'b1;
    localparam logic L = 1'b0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic       op_dir = 1'b0;
    logic [4:0] op_num = 5'd0;
    logic       relock = 1'b0;
    logic       unlocked;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seq_lock_fsm u_seq_lock_fsm (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_dir(op_dir),
        .op_num(op_num), .relock(relock), .unlocked(unlocked)
    );

    task automatic check(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: unlocked actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; op_valid = 1'b0; relock = 1'b0;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic send(input logic d, input logic [4:0] n);
        @(negedge clk); op_valid = 1'b1; op_dir = d; op_num = n;
        @(negedge clk); op_valid = 1'b0;
    endtask

    task automatic pulse_relock();
        @(negedge clk); relock = 1'b1;
        @(negedge clk); relock = 1'b0;
    endtask

    task automatic open_lock();
        send(R, 5'd13); send(L, 5'd22); send(R, 5'd3);
    endtask

    task automatic t_reset();
        do_reset();
        check(unlocked, 1'b0, "R1", "after reset");
    endtask

    task automatic t_full_sequence();
        do_reset();
        send(R, 5'd13); check(unlocked, 1'b0, "R4", "after step one");
        send(L, 5'd22); check(unlocked, 1'b0, "R2", "after step two");
        send(R, 5'd3);  check(unlocked, 1'b1, "R10", "default combination opens");
        repeat (3) @(negedge clk);
        check(unlocked, 1'b1, "R4", "stays open");
    endtask

    task automatic t_strobe_needed();
        do_reset();
        send(R, 5'd13);
        @(negedge clk); op_dir = L; op_num = 5'd22;
        repeat (3) @(negedge clk);
        @(negedge clk); op_dir = R; op_num = 5'd3;
        repeat (3) @(negedge clk);
        check(unlocked, 1'b0, "R3", "unstrobed data not taken");
        send(L, 5'd22); send(R, 5'd3);
        check(unlocked, 1'b1, "R3", "progress held without strobe");
    endtask

    task automatic t_direction();
        do_reset();
        send(R, 5'd13); send(R, 5'd22); send(R, 5'd3);
        check(unlocked, 1'b0, "R5", "wrong direction on step two");
        send(L, 5'd13); send(L, 5'd22); send(R, 5'd3);
        check(unlocked, 1'b0, "R5", "wrong direction on step one");
        open_lock();
        check(unlocked, 1'b1, "R5", "recovers after direction misses");
    endtask

    task automatic t_miss_to_start();
        do_reset();
        send(R, 5'd13); send(L, 5'd22); send(R, 5'd5);
        send(L, 5'd22); send(R, 5'd3);
        check(unlocked, 1'b0, "R6", "miss at step three falls to start");
        do_reset();
        send(R, 5'd13); send(R, 5'd13); send(L, 5'd22); send(R, 5'd3);
        check(unlocked, 1'b0, "R6", "repeated first step is not re-examined");
    endtask

    task automatic t_wrong_order();
        do_reset();
        send(L, 5'd22); send(R, 5'd13); send(R, 5'd3);
        check(unlocked, 1'b0, "R7", "order 2,1,3");
        do_reset();
        send(R, 5'd3); send(L, 5'd22); send(R, 5'd13);
        check(unlocked, 1'b0, "R7", "order 3,2,1");
        do_reset();
        send(R, 5'd13); send(R, 5'd3); send(L, 5'd22);
        check(unlocked, 1'b0, "R7", "order 1,3,2");
    endtask

    task automatic t_relock();
        do_reset();
        open_lock();
        pulse_relock();
        check(unlocked, 1'b0, "R8", "relock closes open lock");
        send(R, 5'd13); pulse_relock(); send(L, 5'd22); pulse_relock(); send(R, 5'd3);
        check(unlocked, 1'b1, "R8", "relock while closed keeps progress");
    endtask

    task automatic t_open_ignores();
        do_reset();
        open_lock();
        send(L, 5'd7); send(R, 5'd13); send(R, 5'd31);
        check(unlocked, 1'b1, "R9", "operations while open ignored");
    endtask

    task automatic t_reset_open();
        do_reset();
        open_lock();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(unlocked, 1'b0, "R1", "reset closes open lock");
    endtask

    initial begin
        t_reset();
        t_full_sequence();
        t_strobe_needed();
        t_direction();
        t_miss_to_start();
        t_wrong_order();
        t_relock();
        t_open_ignores();
        t_reset_open();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule